// File: doc/BRIEF.md
# Mapped Dual-Channel Interrupt Controller

This block collects a set of external interrupt wires and presents them to a processor on two request lines: a fast channel and a normal channel. Between the wires and the channels sits a layer of logical interrupts. Each logical interrupt has its own control word. That word picks which external wire feeds it, whether the wire is sensed as a level or as an edge, which polarity counts as active, and whether the interrupt may raise its channel's request.

Logical interrupts 0 to N_IRQ-1 belong to the normal channel. The following N_FIQ logical interrupts belong to the fast channel. The two channels are built from the same logic and never interact. Each channel reports a registered request bit and the lowest-numbered enabled pending interrupt. The processor gives the fast line precedence, and the status word places the fast channel in its upper half to match.

Software configures the block through a flat word-addressed register port. The same port is used to read back pending state and channel status, and to clear latched edge events.

Top module: `dual_intc`

## Requirements
- R1: After reset both request outputs and both index outputs are 0, every control word reads 0, and both pending words read 0.
- R2: The control word of logical interrupt n sits at address n (0 to N_IRQ+N_FIQ-1). Its fields are: bits [7:0] external input select, bit 8 edge mode (1) or level mode (0), bit 9 active-low (1) or active-high (0), bit 10 enable. A read returns bits [10:0] as written.
- R3: In level mode a logical interrupt is pending exactly while its selected synchronized input, XORed with the active-low bit, is 1. Nothing is latched.
- R4: In edge mode an inactive-to-active transition of the selected input sets pending. Pending stays set after the input returns inactive. An input held active does not set pending again after a clear.
- R5: Writing 1s to address 0x22 (normal channel) or 0x23 (fast channel) clears the edge-mode pending bits at those local positions. Such a write has no effect on a level-mode interrupt whose input is still active.
- R6: A pending interrupt whose enable bit is 0 appears in the pending word (0x20 normal, 0x21 fast, bit = local index) but raises no request and is never reported as the index.
- R7: A channel's request is 1 exactly when it has at least one enabled pending interrupt. Its index is the lowest-numbered such interrupt, and the index is 0 while the request is 0.
- R8: With a level interrupt already enabled, a change on its external input reaches the request output at the fourth rising clock edge after the change.
- R9: Logical interrupt N_IRQ+k drives the fast channel with local index k. The two channels evaluate independently and may both request at once.
- R10: Address 0x24 returns the status word: normal index in bits [7:0], normal request in bit 8, fast index in bits [23:16], fast request in bit 24. Every read returns the addressed word at the clock edge after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_in | input | N_EXT | Asynchronous external interrupt wires |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Word address for read and write |
| reg_wdata | input | WDW | Write data |
| reg_rdata | output | 32 | Registered read data |
| irq_req | output | 1 | Normal channel request |
| irq_idx | output | clog2(N_IRQ) | Lowest enabled pending normal interrupt |
| fiq_req | output | 1 | Fast channel request |
| fiq_idx | output | clog2(N_FIQ) | Lowest enabled pending fast interrupt |

## Verification
The bench builds the block with its defaults: 16 external wires, 20 normal and 4 fast logical interrupts. This lets several logical interrupts share one wire, lets select values land anywhere in the wire range, and allows both channels to be full or empty at once. Random level-mode mappings with random polarity and enables stress the lowest-index search and the pending words of both channels. Directed sequences cover edge latching, falling-edge sensing on the fast channel, clears against edge and level interrupts, and the exact four-edge input latency.

// File: rtl/intc_pkg.sv
package intc_pkg;
  // control word layout, msb first: enable, active-low, edge mode, select
  typedef struct packed {
    logic       en;
    logic       low;
    logic       edge_m;
    logic [7:0] sel;
  } cfg_t;

  localparam int CFGW = $bits(cfg_t);
  localparam int AW   = 6;
  localparam int RDW  = 32;

  localparam logic [AW-1:0] A_IRQ_PEND = 6'h20;
  localparam logic [AW-1:0] A_FIQ_PEND = 6'h21;
  localparam logic [AW-1:0] A_IRQ_CLR  = 6'h22;
  localparam logic [AW-1:0] A_FIQ_CLR  = 6'h23;
  localparam logic [AW-1:0] A_STATUS   = 6'h24;
endpackage

// File: rtl/intc_sync.sv
module intc_sync #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/intc_source.sv
module intc_source
  import intc_pkg::*;
#(
  parameter int N_EXT = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_EXT-1:0] ext_s,
  input  cfg_t             cfg,
  input  logic             clr,
  output logic             pend
);
  localparam int SELW = (N_EXT > 1) ? $clog2(N_EXT) : 1;

  logic [SELW-1:0] sel_i;
  logic            sel_ok;
  logic            active;
  logic            prev_q;

  assign sel_i  = cfg.sel[SELW-1:0];
  assign sel_ok = ({24'd0, cfg.sel} < N_EXT);
  assign active = (sel_ok ? ext_s[sel_i] : 1'b0) ^ cfg.low;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      pend   <= 1'b0;
    end else begin
      prev_q <= active;
      if (cfg.edge_m) begin
        if (active && !prev_q) pend <= 1'b1;
        else if (clr)          pend <= 1'b0;
      end else begin
        pend <= active;
      end
    end
  end

  AST_EDGE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (cfg.edge_m && pend && !clr) |=> pend) else $error("edge pending lost"); // R4
  AST_LEVEL_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (!cfg.edge_m) |=> (pend == $past(active))) else $error("level pending stale"); // R3
endmodule

// File: rtl/intc_channel.sv
module intc_channel #(
  parameter int N  = 20,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  pend_en,
  output logic          req,
  output logic [IW-1:0] idx
);
  logic [IW-1:0] idx_n;
  logic [N-1:0]  lowmask;

  always_comb begin
    idx_n = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend_en[i]) idx_n = IW'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req <= 1'b0;
      idx <= '0;
    end else begin
      req <= |pend_en;
      idx <= idx_n;
    end
  end

  always_comb begin
    lowmask = '0;
    for (int i = 0; i < N; i++) lowmask[i] = (IW'(i) < idx);
  end

  AST_IDX_LOWEST: assert property (@(posedge clk) disable iff (rst)
    req |-> (($past(pend_en) & lowmask) == '0)) else $error("index not lowest"); // R7
  AST_IDX_PENDING: assert property (@(posedge clk) disable iff (rst)
    req |-> (($past(pend_en) >> idx) & N'(1)) != '0) else $error("index not pending"); // R7
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !req |-> (idx == '0)) else $error("idle index nonzero"); // R7
endmodule

// File: rtl/dual_intc.sv
module dual_intc
  import intc_pkg::*;
#(
  parameter int N_EXT = 16,
  parameter int N_IRQ = 20,
  parameter int N_FIQ = 4,
  parameter int WDW   = (N_IRQ > 11) ? N_IRQ : 11
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [N_EXT-1:0]         ext_in,
  input  logic                     reg_we,
  input  logic [5:0]               reg_addr,
  input  logic [WDW-1:0]           reg_wdata,
  output logic [31:0]              reg_rdata,
  output logic                     irq_req,
  output logic [$clog2(N_IRQ)-1:0] irq_idx,
  output logic                     fiq_req,
  output logic [$clog2(N_FIQ)-1:0] fiq_idx
);
  localparam int NL = N_IRQ + N_FIQ;

  logic [N_EXT-1:0] ext_s;
  cfg_t             cfg_q [NL];
  logic [NL-1:0]    pend_all;
  logic [NL-1:0]    en_all;
  logic [NL-1:0]    clr_all;
  logic [N_IRQ-1:0] irq_clr;
  logic [N_FIQ-1:0] fiq_clr;
  logic [31:0]      rd_n;

  intc_sync #(.W(N_EXT)) u_sync (
    .clk(clk), .rst(rst), .d(ext_in), .q(ext_s)
  );

  always_ff @(posedge clk) begin
    for (int i = 0; i < NL; i++) begin
      if (rst)
        cfg_q[i] <= '0;
      else if (reg_we && reg_addr == 6'(i))
        cfg_q[i] <= cfg_t'(reg_wdata[CFGW-1:0]);
    end
  end

  assign irq_clr = (reg_we && reg_addr == A_IRQ_CLR) ? reg_wdata[N_IRQ-1:0] : '0;
  assign fiq_clr = (reg_we && reg_addr == A_FIQ_CLR) ? reg_wdata[N_FIQ-1:0] : '0;
  assign clr_all = {fiq_clr, irq_clr};

  for (genvar g = 0; g < NL; g++) begin : g_src
    assign en_all[g] = cfg_q[g].en;
    intc_source #(.N_EXT(N_EXT)) u_src (
      .clk(clk), .rst(rst), .ext_s(ext_s), .cfg(cfg_q[g]),
      .clr(clr_all[g]), .pend(pend_all[g])
    );
  end

  intc_channel #(.N(N_IRQ)) u_irq (
    .clk(clk), .rst(rst), .pend_en(pend_all[N_IRQ-1:0] & en_all[N_IRQ-1:0]),
    .req(irq_req), .idx(irq_idx)
  );

  intc_channel #(.N(N_FIQ)) u_fiq (
    .clk(clk), .rst(rst), .pend_en(pend_all[NL-1:N_IRQ] & en_all[NL-1:N_IRQ]),
    .req(fiq_req), .idx(fiq_idx)
  );

  always_comb begin
    rd_n = '0;
    for (int i = 0; i < NL; i++) begin
      if (reg_addr == 6'(i)) rd_n = 32'(cfg_q[i]);
    end
    if (reg_addr == A_IRQ_PEND) rd_n = 32'(pend_all[N_IRQ-1:0]);
    if (reg_addr == A_FIQ_PEND) rd_n = 32'(pend_all[NL-1:N_IRQ]);
    if (reg_addr == A_STATUS) begin
      rd_n[7:0]   = 8'(irq_idx);
      rd_n[8]     = irq_req;
      rd_n[23:16] = 8'(fiq_idx);
      rd_n[24]    = fiq_req;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_n;
  end

  AST_REQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> $past(|(pend_all[N_IRQ-1:0] & en_all[N_IRQ-1:0]))) else $error("spurious normal request"); // R7
  AST_FIQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (rst)
    fiq_req |-> $past(|(pend_all[NL-1:N_IRQ] & en_all[NL-1:N_IRQ]))) else $error("spurious fast request"); // R9
endmodule

// File: tb/tb_dual_intc.sv
module tb_dual_intc;
  localparam int N_EXT = 16;
  localparam int N_IRQ = 20;
  localparam int N_FIQ = 4;
  localparam int NL    = N_IRQ + N_FIQ;
  localparam int WDW   = 20;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [N_EXT-1:0] ext_in = '0;
  logic             reg_we = 1'b0;
  logic [5:0]       reg_addr = '0;
  logic [WDW-1:0]   reg_wdata = '0;
  logic [31:0]      reg_rdata;
  logic             irq_req, fiq_req;
  logic [4:0]       irq_idx;
  logic [1:0]       fiq_idx;

  int n_chk = 0;
  int n_bad = 0;

  logic [7:0] b_sel [NL];
  bit         b_low [NL];
  bit         b_en  [NL];

  always #5 clk = ~clk;

  dual_intc #(.N_EXT(N_EXT), .N_IRQ(N_IRQ), .N_FIQ(N_FIQ)) dut (
    .clk(clk), .rst(rst), .ext_in(ext_in), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_req(irq_req), .irq_idx(irq_idx),
    .fiq_req(fiq_req), .fiq_idx(fiq_idx)
  );

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [5:0] a, input logic [WDW-1:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  // level-mode model: pending of logical n from bench config
  function automatic bit lvl_pend(input int n);
    return (int'(b_sel[n]) < N_EXT ? ext_in[b_sel[n][3:0]] : 1'b0) ^ b_low[n];
  endfunction

  function automatic logic [31:0] exp_pendw(input int base, input int cnt);
    logic [31:0] r = '0;
    for (int i = 0; i < cnt; i++) r[i] = lvl_pend(base + i);
    return r;
  endfunction

  function automatic logic [31:0] exp_idx(input int base, input int cnt);
    for (int i = 0; i < cnt; i++) if (lvl_pend(base + i) && b_en[base + i]) return i;
    return 0;
  endfunction

  function automatic logic [31:0] exp_req(input int base, input int cnt);
    for (int i = 0; i < cnt; i++) if (lvl_pend(base + i) && b_en[base + i]) return 1;
    return 0;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL R0: watchdog actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'h1DC0_0EA7));
    wait_n(3);
    rst = 1'b0;
    wait_n(1);

    // R1 reset state
    chk("R1 irq_req", 32'(irq_req), 0);
    chk("R1 fiq_req", 32'(fiq_req), 0);
    chk("R1 idx", 32'({irq_idx, fiq_idx}), 0);
    rd(6'h24, d); chk("R1 status", d, 0);
    rd(6'h20, d); chk("R1 irq pend", d, 0);
    rd(6'd23, d); chk("R1 cfg", d, 0);

    // R8 latency: logical 0, level, high, enabled, select 2
    wr(6'd0, 20'h402);
    ext_in[2] = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R8 not yet", 32'(irq_req), 0);
    @(negedge clk);
    chk("R8 fourth edge", 32'(irq_req), 1);
    chk("R8 idx", 32'(irq_idx), 0);

    // R3 R6 R7 R9 random level mappings
    for (int it = 0; it < 40; it++) begin
      for (int n = 0; n < NL; n++) begin
        b_sel[n] = 8'($urandom_range(0, N_EXT - 1));
        b_low[n] = 1'($urandom_range(0, 1));
        b_en[n]  = ($urandom_range(0, 9) < 3);
        wr(6'(n), {9'd0, b_en[n], b_low[n], 1'b0, b_sel[n]});
      end
      ext_in = 16'($urandom);
      wait_n(6);
      chk("R7 irq_req", 32'(irq_req), exp_req(0, N_IRQ));
      chk("R7 irq_idx", 32'(irq_idx), exp_idx(0, N_IRQ));
      chk("R9 fiq_req", 32'(fiq_req), exp_req(N_IRQ, N_FIQ));
      chk("R9 fiq_idx", 32'(fiq_idx), exp_idx(N_IRQ, N_FIQ));
      rd(6'h20, d); chk("R3 irq pend", d, exp_pendw(0, N_IRQ));
      rd(6'h21, d); chk("R6 fiq pend", d, exp_pendw(N_IRQ, N_FIQ));
    end

    // back to quiet state
    ext_in = '0;
    for (int n = 0; n < NL; n++) wr(6'(n), '0);
    wait_n(6);
    chk("R7 quiet", 32'({irq_req, fiq_req}), 0);

    // R4 edge latch on logical 5, select 3, rising
    wr(6'd5, 20'h503);
    wait_n(4);
    wr(6'h22, 20'hFFFFF);
    wait_n(2);
    ext_in[3] = 1'b1;
    wait_n(6);
    chk("R4 edge set", 32'(irq_req), 1);
    chk("R4 edge idx", 32'(irq_idx), 5);
    ext_in[3] = 1'b0;
    wait_n(6);
    chk("R4 edge held", 32'(irq_req), 1);
    wr(6'h22, 20'h00020);
    wait_n(3);
    chk("R5 edge cleared", 32'(irq_req), 0);
    rd(6'h20, d); chk("R5 pend bit", d, 0);
    ext_in[3] = 1'b1;
    wait_n(6);
    chk("R4 second edge", 32'(irq_req), 1);
    wr(6'h22, 20'h00020);
    wait_n(6);
    chk("R4 no retrigger", 32'(irq_req), 0);

    // R5 clear has no effect on level: logical 8, select 4
    wr(6'd8, 20'h404);
    ext_in[4] = 1'b1;
    wait_n(6);
    wr(6'h22, 20'h00100);
    wait_n(4);
    chk("R5 level kept", 32'(irq_req), 1);
    chk("R5 level idx", 32'(irq_idx), 8);

    // R4 R9 falling edge on fast local 1 (logical 21), select 7
    ext_in[7] = 1'b1;
    wait_n(4);
    wr(6'd21, 20'h707);
    wait_n(4);
    wr(6'h23, 20'h0000F);
    wait_n(3);
    chk("R9 fast idle", 32'(fiq_req), 0);
    ext_in[7] = 1'b0;
    wait_n(6);
    chk("R4 falling edge", 32'(fiq_req), 1);
    chk("R9 fast idx", 32'(fiq_idx), 1);
    chk("R9 normal still", 32'(irq_req), 1);
    rd(6'h24, d); chk("R10 status", d, 32'h0101_0108);
    rd(6'h21, d); chk("R9 fast pend", d, 32'h2);

    // R6 disabled pending: logical 2, select 9, no enable
    wr(6'd2, 20'h009);
    ext_in[9] = 1'b1;
    wait_n(6);
    rd(6'h20, d); chk("R6 pend visible", d, 32'h0000_0104);
    chk("R6 not indexed", 32'(irq_idx), 8);

    // R2 readback
    rd(6'd21, d); chk("R2 cfg readback", d, 32'h707);
    rd(6'd5, d);  chk("R2 cfg readback", d, 32'h503);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule